// File: doc/BRIEF.md
# Byte-Addressable Bus Memory Slave

This block is an AHB-Lite subordinate with a small internal RAM (256 bytes by default) on a 32-bit data bus. Each bus cycle with the global ready input high is an address phase. The block decides there whether a transfer is meant for it and, if so, stores the address, direction and size. The next cycle is the data phase. A write takes its bytes from the write-data input and stores them on the byte lanes that the stored address and size select. A read places the addressed bytes on those lanes of the read-data output and drives every other lane to zero.

The bus carries its own back-pressure. The slave's `readyout_o` is its ready, and the interconnect returns the combined ready on `ready_i`. While `ready_i` is low the current data phase is stretched. The held transfer keeps its stored controls and no new address phase is sampled. A parameter `WAIT_STATES` holds `readyout_o` low for a fixed number of cycles at the start of every data phase. The response is always OKAY.

Top module: `bmem_ahb_slave`

## Requirements
- R1: After reset `readyout_o` is 1, `resp_o` is 0 and `rdata_o` is 0.
- R2: An address phase is accepted only when `ready_i`=1, `sel_i`=1 and `trans_i` is 2 (first beat) or 3 (following beat). `trans_i` 0 (idle) or 1 (pause), or `sel_i`=0, leaves the memory unchanged.
- R3: A write stores only the selected lanes. Lane k carries bits 8k+7..8k and holds byte address {addr[7:2],k}. `size_i` 0 selects lane addr[1:0]. Size 1 selects lanes 1:0 when addr[1]=0 and lanes 3:2 when addr[1]=1. Size 2 selects all four lanes.
- R4: Read data appears in the data phase after its address phase. The selected lanes carry the stored bytes at their natural positions and the other lanes read 0.
- R5: `rdata_o` is 0 in every cycle that is not the completing cycle of a read data phase.
- R6: `readyout_o` is 1 whenever no data phase is pending. In every data phase it is 0 for exactly `WAIT_STATES` cycles and then 1.
- R7: While `ready_i` is 0 the inputs are not sampled. Controls presented then are not performed, and the held transfer completes with its own address.
- R8: `resp_o` is always 0 (OKAY).
- R9: A `size_i` above 2 (wider than the bus) is not performed and leaves memory unchanged.
- R10: A read that directly follows a write to the same address returns the newly written data.
- R11: A 4-beat incrementing byte burst (one first beat, then three following beats) over addresses 0x20 to 0x23 writes and reads those four bytes and no others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| sel_i | input | 1 | Slave selected for this address phase |
| addr_i | input | AW (8) | Byte address |
| trans_i | input | 2 | Transfer kind: 0 idle, 1 pause, 2 first beat, 3 following beat |
| write_i | input | 1 | 1 write, 0 read |
| size_i | input | 3 | log2 of bytes per beat |
| ready_i | input | 1 | Combined bus ready |
| wdata_i | input | DATA_W (32) | Write data, valid in the data phase |
| readyout_o | output | 1 | This slave's ready |
| rdata_o | output | DATA_W (32) | Read data |
| resp_o | output | 1 | Response, always OKAY (0) |

## Verification
A stored transfer flag that sets when it should not would show at the ports as soon as the following read of the affected address. That read would return a byte that an idle, paused, deselected or stalled cycle overwrote. A wrong lane mask shows in the same read as a shifted or leaked byte, or a nonzero byte on an unselected lane. A wait counter that loads or counts wrongly changes the length of the low stretch of `readyout_o` in the very data phase it belongs to. A stuck read enable shows within one cycle as nonzero `rdata_o` on a write or idle cycle.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  localparam logic RESP_OKAY = 1'b0;

  // A beat moves data only for the first and following beat kinds.
  function automatic logic moves_data(input logic [1:0] t);
    return (t == TR_NONSEQ) || (t == TR_SEQ);
  endfunction

endpackage

// File: rtl/bmem_capture.sv
module bmem_capture
  import bmem_pkg::*;
#(
  parameter int AW       = 8,
  parameter int MAX_SIZE = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic [1:0]    trans_i,
  input  logic          write_i,
  input  logic [2:0]    size_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ready_i,
  output logic          accept_o,
  output logic          dp_valid_o,
  output logic          dp_write_o,
  output logic [2:0]    dp_size_o,
  output logic [AW-1:0] dp_addr_o
);

  localparam logic [2:0] SZ_LIMIT = 3'(MAX_SIZE);

  assign accept_o = ready_i && sel_i && moves_data(trans_i) && (size_i <= SZ_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_valid_o <= 1'b0;
      dp_write_o <= 1'b0;
      dp_size_o  <= '0;
      dp_addr_o  <= '0;
    end else if (ready_i) begin
      dp_valid_o <= accept_o;
      if (accept_o) begin
        dp_write_o <= write_i;
        dp_size_o  <= size_i;
        dp_addr_o  <= addr_i;
      end
    end
  end

  // R2: a pending transfer only starts from a selected, ready address phase
  p_start_needs_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dp_valid_o) |-> $past(ready_i && sel_i));

  // R7: a stalled bus freezes the stored transfer
  p_hold_on_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> ($stable(dp_valid_o) && $stable(dp_addr_o) && $stable(dp_write_o)));

endmodule

// File: rtl/bmem_wait.sv
module bmem_wait #(
  parameter int WAIT_STATES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  output logic readyout_o
);

  localparam int CW = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WAIT_STATES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain <= '0;
    end else if (accept_i) begin
      remain <= LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign readyout_o = (remain == '0);

endmodule

// File: rtl/bmem_lanes.sv
module bmem_lanes #(
  parameter int AW     = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dp_valid_i,
  input  logic              dp_write_i,
  input  logic [2:0]        dp_size_i,
  input  logic [AW-1:0]     dp_addr_i,
  input  logic              fire_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int LANES  = DATA_W / 8;
  localparam int LW     = $clog2(LANES);
  localparam int WORDS  = (2 ** AW) / LANES;
  localparam int WIDX_W = AW - LW;

  logic [LANES-1:0]  mask;
  logic [LANES-1:0]  we;
  logic [WIDX_W-1:0] widx;
  logic              rd_en;
  int                nbytes;
  int                base;

  // Lane selection: a beat of 2**size bytes sits on lanes aligned to its own size.
  always_comb begin
    nbytes = 1 << dp_size_i;
    base   = int'(dp_addr_i[LW-1:0]) & ~(nbytes - 1);
    mask   = ({LANES{1'b1}} >> (LANES - nbytes)) << base;
  end

  assign widx  = dp_addr_i[AW-1:LW];
  assign rd_en = dp_valid_i && !dp_write_i && fire_i;
  assign we    = mask & {LANES{dp_valid_i && dp_write_i && fire_i}};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [7:0] mem [WORDS];

    always_ff @(posedge clk_i) begin
      if (we[k]) begin
        mem[widx] <= wdata_i[8*k +: 8];
      end
    end

    assign rdata_o[8*k +: 8] = (rd_en && mask[k]) ? mem[widx] : 8'h00;
  end

  // R3: a byte-sized write touches exactly one lane
  p_byte_one_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && dp_valid_i && dp_write_i && dp_size_i == 3'd0) |-> ($countones(we) == 1));

endmodule

// File: rtl/bmem_ahb_slave.sv
module bmem_ahb_slave
  import bmem_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DATA_W      = 32,
  parameter int WAIT_STATES = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              readyout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              resp_o
);

  localparam int MAX_SIZE = $clog2(DATA_W / 8);

  logic          accept;
  logic          dp_valid;
  logic          dp_write;
  logic [2:0]    dp_size;
  logic [AW-1:0] dp_addr;

  bmem_capture #(.AW(AW), .MAX_SIZE(MAX_SIZE)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .trans_i    (trans_i),
    .write_i    (write_i),
    .size_i     (size_i),
    .addr_i     (addr_i),
    .ready_i    (ready_i),
    .accept_o   (accept),
    .dp_valid_o (dp_valid),
    .dp_write_o (dp_write),
    .dp_size_o  (dp_size),
    .dp_addr_o  (dp_addr)
  );

  bmem_wait #(.WAIT_STATES(WAIT_STATES)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .readyout_o (readyout_o)
  );

  bmem_lanes #(.AW(AW), .DATA_W(DATA_W)) u_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dp_valid_i (dp_valid),
    .dp_write_i (dp_write),
    .dp_size_i  (dp_size),
    .dp_addr_i  (dp_addr),
    .fire_i     (readyout_o),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o)
  );

  assign resp_o = RESP_OKAY;

  // R6: with nothing pending the slave never stalls the bus
  p_ready_when_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dp_valid |-> readyout_o);

  // R5: read lanes stay quiet outside a read data phase
  p_rdata_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dp_valid && !dp_write) |-> (rdata_o == '0));

endmodule

// File: tb/sim_bmem_ahb_slave.sv
`timescale 1ns/1ps
module sim_bmem_ahb_slave;

  localparam int WS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  trans = 2'd0;
  logic        wr = 1'b0;
  logic [2:0]  size = 3'd0;
  logic        ready;
  logic [31:0] wdata = '0;
  logic        readyout;
  logic [31:0] rdata;
  logic        resp;

  int total = 0;
  int bad = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  logic [7:0]  model [256];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;
  assign ready = readyout;

  bmem_ahb_slave #(.AW(8), .DATA_W(32), .WAIT_STATES(WS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .addr_i(addr), .trans_i(trans),
    .write_i(wr), .size_i(size), .ready_i(ready), .wdata_i(wdata),
    .readyout_o(readyout), .rdata_o(rdata), .resp_o(resp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lanes(input logic [2:0] sz, input logic [7:0] a);
    case (sz)
      3'd0:    return 4'b0001 << a[1:0];
      3'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // Driver: present one address phase, wait for it to be taken, then supply its write data.
  task automatic drive(input logic s, input logic [1:0] tr, input logic w, input logic [2:0] sz,
                       input logic [7:0] a, input logic [31:0] wd, input string tag);
    bit taken;
    logic [3:0] m;
    logic [31:0] e;
    sel = s; trans = tr; wr = w; size = sz; addr = a;
    taken = 1'b0;
    while (!taken) begin
      taken = readyout;
      @(negedge clk);
    end
    if (s && tr[1] && sz <= 3'd2) begin
      m = lanes(sz, a);
      e = '0;
      for (int k = 0; k < 4; k++) begin
        if (m[k]) begin
          if (w) model[{a[7:2], 2'(k)}] = wd[8*k +: 8];
          else   e[8*k +: 8] = model[{a[7:2], 2'(k)}];
        end
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    wdata = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 1'b0, 3'd0, 8'h00, 32'h0, "idle");
  endtask

  // Monitor: follows data phases at the ports and compares against the scoreboard.
  initial begin
    bit dp = 1'b0;
    int low = 0;
    bit acc;
    forever begin
      @(negedge clk);
      #1;
      if (mon_on) begin
        acc = readyout && sel && trans[1] && (size <= 3'd2);
        check("R8 resp", {31'd0, resp}, 32'd0);
        if (dp) begin
          if (readyout) begin
            check("R6 wait length", low, WS);
            if (exp_q.size() == 0) begin
              check("R4 scoreboard empty", 32'd1, 32'd0);
            end else begin
              check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
            dp = 1'b0;
          end else begin
            low++;
          end
        end else begin
          check("R6 ready when free", {31'd0, readyout}, 32'd1);
          check("R5 rdata quiet", rdata, 32'd0);
        end
        if (acc) begin
          dp = 1'b1;
          low = 0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 readyout", {31'd0, readyout}, 32'd1);
    check("R1 resp", {31'd0, resp}, 32'd0);
    check("R1 rdata", rdata, 32'd0);
    @(negedge clk);
    mon_on = 1'b1;

    // Fill the whole memory with word writes, then read part of it back.
    for (int i = 0; i < 64; i++)
      drive(1'b1, 2'd2, 1'b1, 3'd2, 8'(4*i), {8'(i), 8'(i ^ 8'h5a), 8'(~i), 8'(i + 8'h11)}, "R3 fill");
    for (int i = 0; i < 16; i++)
      drive(1'b1, 2'd2, 1'b0, 3'd2, 8'(4*i), 32'h0, "R4 word read");

    // Sub-word lanes
    drive(1'b1, 2'd2, 1'b1, 3'd0, 8'h11, 32'h0000ab00, "R3 byte write");
    drive(1'b1, 2'd2, 1'b0, 3'd2, 8'h10, 32'h0, "R3 byte lane readback");
    drive(1'b1, 2'd2, 1'b1, 3'd1, 8'h16, 32'hbeef0000, "R3 half write");
    drive(1'b1, 2'd2, 1'b0, 3'd2, 8'h14, 32'h0, "R3 half lane readback");
    drive(1'b1, 2'd2, 1'b0, 3'd1, 8'h16, 32'h0, "R4 half read upper");
    drive(1'b1, 2'd2, 1'b0, 3'd1, 8'h08, 32'h0, "R4 half read lower");
    drive(1'b1, 2'd2, 1'b0, 3'd0, 8'h13, 32'h0, "R4 byte read lane3");

    // Ignored beats
    drive(1'b1, 2'd0, 1'b1, 3'd2, 8'h30, 32'hdeadbeef, "R2 idle");
    drive(1'b1, 2'd1, 1'b1, 3'd2, 8'h30, 32'hdeadbeef, "R2 pause");
    drive(1'b0, 2'd2, 1'b1, 3'd2, 8'h30, 32'hdeadbeef, "R2 deselected");
    drive(1'b1, 2'd2, 1'b0, 3'd2, 8'h30, 32'h0, "R2 memory unchanged");
    drive(1'b1, 2'd2, 1'b1, 3'd3, 8'h34, 32'hcafef00d, "R9 oversize");
    drive(1'b1, 2'd2, 1'b0, 3'd2, 8'h34, 32'h0, "R9 memory unchanged");

    // Read straight after write
    drive(1'b1, 2'd2, 1'b1, 3'd2, 8'h38, 32'h12345678, "R10 write");
    drive(1'b1, 2'd2, 1'b0, 3'd2, 8'h38, 32'h0, "R10 read after write");

    // Incrementing byte burst
    for (int i = 0; i < 4; i++)
      drive(1'b1, (i == 0) ? 2'd2 : 2'd3, 1'b1, 3'd0, 8'(8'h20 + i), 32'(8'h90 + i) << (8*i), "R11 burst write");
    for (int i = 0; i < 4; i++)
      drive(1'b1, (i == 0) ? 2'd2 : 2'd3, 1'b0, 3'd0, 8'(8'h20 + i), 32'h0, "R11 burst read");
    drive(1'b1, 2'd2, 1'b0, 3'd2, 8'h20, 32'h0, "R11 burst word");
    drive(1'b1, 2'd2, 1'b0, 3'd2, 8'h24, 32'h0, "R11 neighbour untouched");

    // Controls changed while stalled must not be taken
    drive(1'b1, 2'd2, 1'b1, 3'd2, 8'h40, 32'h0badf00d, "R7 held write");
    sel = 1'b1; trans = 2'd2; wr = 1'b1; size = 3'd2; addr = 8'h44;
    while (!readyout) @(negedge clk);
    sel = 1'b0; trans = 2'd0; wr = 1'b0; addr = 8'h00;
    @(negedge clk);
    drive(1'b1, 2'd2, 1'b0, 3'd2, 8'h40, 32'h0, "R7 held address used");
    drive(1'b1, 2'd2, 1'b0, 3'd2, 8'h44, 32'h0, "R7 stalled controls ignored");

    idle(4);
    check("R4 scoreboard drained", exp_q.size(), 32'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule